// File: doc/BRIEF.md
# Descriptor Ring Copy Queue

This block queues flat memory-copy requests for a separate copy engine. Each request gives a 32-bit offset into an instruction stream, a 32-bit byte length and a 64-bit destination. The block forms the 64-bit source by adding the offset to a configured stream base. It then cuts the transfer into chunks of at most `CHUNK_BYTES` and writes one descriptor per chunk into consecutive slots of a power-of-two ring. The descriptor holds the source, the length and the destination.

A requester hands over a request on a valid/ready handshake. One cycle later the block reports the ticket of the first slot used, the slot index and the number of slots used. The ticket is the value of a 64-bit submit counter, which only ever counts up. A consumer reads the oldest posted descriptor and retires it, which advances a 64-bit completion counter. Each slot header carries a chunk index, a two-bit lap number and a two-bit state. A poll port takes a ticket and a slot count and reports busy until every one of those slots has been retired. It decides this from the slot headers by comparing laps, not by comparing the two counters.

Top module: `desc_ring_queue`

## Requirements
- R1: After reset, no descriptor is offered (`cons_valid`=0) and neither `enq_done` nor `enq_err` is high. A request that fits an empty ring sees `req_ready`=1. A poll of ticket 0 with count 1 reports busy, and a poll with count 0 reports not busy.
- R2: An accepted request produces `enq_done`=1 for one cycle on the edge after acceptance. At the same time the block presents `enq_ticket` equal to the submit count before the request, `enq_slot` equal to that ticket modulo `DEPTH`, and `enq_count` equal to ceil(length / `CHUNK_BYTES`).
- R3: Chunk k of a request has source base + offset + k·`CHUNK_BYTES`. The base + offset sum carries from bit 31 into bit 32. The chunk's destination is dst + k·`CHUNK_BYTES`. Its length is `CHUNK_BYTES`, except for the last chunk, which takes the remainder.
- R4: A zero-length request is taken with `req_ready`=1. It pulses `enq_err` and not `enq_done`, and it allocates no slot: the next accepted request receives the ticket it would have had otherwise.
- R5: A request that needs more than `DEPTH` slots is rejected in the same way as R4.
- R6: `req_ready` is 0 for a valid-length request whose slot count exceeds the free slots (`DEPTH` minus outstanding). No slot is allocated until retirements make room. A full ring blocks every non-error request.
- R7: `cons_valid` is 1 exactly when posted slots are outstanding. The descriptor shown is the oldest one, in ticket order. `cons_retire` advances the completion counter by one and is ignored while `cons_valid`=0.
- R8: Tickets keep growing past `DEPTH`. The slot index wraps modulo `DEPTH`, and the lap number stored in a slot changes on every wrap.
- R9: `poll_busy` is 1 while any of the `poll_count` slots starting at `poll_ticket` is unretired, and 0 once all are retired. This stays true after a later lap has reused those slots.
- R10: `cons_chunk` shows the position k of the offered chunk within its request, as a 3-bit field of the slot header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | 64 | Stream base address added to each offset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_offset | input | 32 | Source offset into the stream |
| req_len | input | 32 | Byte length |
| req_dst | input | 64 | Destination address |
| enq_done | output | 1 | One-cycle pulse: request queued |
| enq_err | output | 1 | One-cycle pulse: request rejected |
| enq_ticket | output | 64 | Ticket of the first slot used |
| enq_slot | output | $clog2(DEPTH) | Index of the first slot used |
| enq_count | output | $clog2(DEPTH)+1 | Number of slots used |
| cons_valid | output | 1 | Oldest posted descriptor is offered |
| cons_src | output | 64 | Offered descriptor source |
| cons_len | output | 32 | Offered descriptor length |
| cons_dst | output | 64 | Offered descriptor destination |
| cons_chunk | output | 3 | Chunk position within its request |
| cons_retire | input | 1 | Retire the offered descriptor |
| poll_ticket | input | 64 | First ticket to poll |
| poll_count | input | $clog2(DEPTH)+1 | Number of slots to poll |
| poll_busy | output | 1 | 1 while any polled slot is unretired |

## Verification
A base whose low word sits just below the 32-bit boundary, combined with large offsets, separates a correct carry into the high word from a plain 32-bit add. Lengths of exactly one chunk, a non-multiple spanning three chunks, exactly `DEPTH` chunks, one byte beyond that, and zero separate the chunk-count, remainder and rejection paths. Random interleaving of requests and retirements, held long enough for tickets to run several laps around the ring, fills the ring to the point where ready drops. It also makes polls of retired tickets whose slots were reused, which tells lap-based completion apart from a stale header state.

// File: rtl/dq_pkg.sv
package dq_pkg;

  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_POSTED = 2'd1,
    ST_DONE   = 2'd2
  } slot_state_e;

  // slot header: chunk position, lap number, state
  typedef struct packed {
    logic [2:0]  chunk;
    logic [1:0]  lap;
    slot_state_e state;
  } slot_hdr_t;

  typedef struct packed {
    logic [63:0] src;
    logic [31:0] len;
    logic [63:0] dst;
  } desc_t;

  // 64-bit plus 32-bit add done in two 32-bit halves, carry passed up
  function automatic logic [63:0] add64_split(input logic [63:0] a, input logic [31:0] b);
    logic [32:0] lo;
    logic [31:0] hi;
    lo = {1'b0, a[31:0]} + {1'b0, b};
    hi = a[63:32] + {31'b0, lo[32]};
    return {hi, lo[31:0]};
  endfunction

  // number of chunks for a byte length, 33 bits so the round-up cannot overflow
  function automatic logic [32:0] chunks_for(input logic [31:0] len, input int unsigned shift);
    logic [32:0] s;
    s = {1'b0, len} + ((33'd1 << shift) - 33'd1);
    return s >> shift;
  endfunction

  // a slot is settled for an expected lap when it was retired in that lap,
  // or when a later lap (one or two ahead) has already reused it
  function automatic logic slot_settled(input slot_hdr_t h, input logic [1:0] exp_lap);
    logic [1:0] diff;
    diff = h.lap - exp_lap;
    return ((diff == 2'd0) && (h.state == ST_DONE)) || (diff == 2'd1) || (diff == 2'd2);
  endfunction

endpackage

// File: rtl/dq_alloc.sv
module dq_alloc
  import dq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int CHUNK_SHIFT = 8,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int CNT_W      = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_len,
  input  logic             retire,
  output logic             req_ready,
  output logic             accept,
  output logic             reject,
  output logic [CNT_W-1:0] needed,
  output logic [CNT_W-1:0] occ,
  output logic [63:0]      submit_cnt,
  output logic [63:0]      comp_cnt
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [32:0]      need_full;
  logic             len_zero;
  logic             too_big;
  logic             bad_len;
  logic [CNT_W-1:0] free_slots;
  logic             fits;

  always_comb begin
    need_full  = chunks_for(req_len, CHUNK_SHIFT);
    len_zero   = (req_len == 32'd0);
    too_big    = (need_full > 33'(DEPTH));
    bad_len    = len_zero || too_big;
    needed     = bad_len ? '0 : need_full[CNT_W-1:0];
    occ        = submit_cnt[CNT_W-1:0] - comp_cnt[CNT_W-1:0];
    free_slots = DEPTH_C - occ;
    fits       = !bad_len && (needed <= free_slots);
    req_ready  = bad_len || fits;
    accept     = req_valid && fits;
    reject     = req_valid && bad_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      submit_cnt <= '0;
      comp_cnt   <= '0;
    end else begin
      if (accept) submit_cnt <= add64_split(submit_cnt, 32'(needed));
      if (retire) comp_cnt   <= add64_split(comp_cnt, 32'd1);
    end
  end

endmodule

// File: rtl/dq_slot_store.sv
module dq_slot_store
  import dq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int CHUNK_SHIFT = 8,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int CNT_W      = IDX_W + 1,
  localparam int LAP_W      = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] needed,
  input  logic [LAP_W-1:0] head,
  input  logic [63:0]      src0,
  input  logic [31:0]      req_len,
  input  logic [63:0]      req_dst,
  input  logic             retire,
  input  logic [IDX_W-1:0] tail_idx,
  output slot_hdr_t        hdrs [DEPTH],
  output desc_t            tail_desc,
  output slot_hdr_t        tail_hdr
);

  localparam logic [31:0] CHUNK_BYTES = 32'd1 << CHUNK_SHIFT;

  desc_t slot_desc [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);

    logic [IDX_W-1:0] rel;
    logic             hit;
    logic             last;
    logic [LAP_W-1:0] tkt;
    logic [63:0]      off64;
    logic [31:0]      rel_bytes;
    desc_t            d_next;
    slot_hdr_t        h_next;
    desc_t            d_r;
    slot_hdr_t        h_r;

    always_comb begin
      rel       = SLOT - head[IDX_W-1:0];
      hit       = accept && ({1'b0, rel} < needed);
      last      = ({1'b0, rel} == (needed - CNT_W'(1)));
      tkt       = head + LAP_W'(rel);
      off64     = 64'(rel) << CHUNK_SHIFT;
      rel_bytes = 32'(rel) << CHUNK_SHIFT;
      d_next.src = src0 + off64;
      d_next.dst = req_dst + off64;
      d_next.len = last ? (req_len - rel_bytes) : CHUNK_BYTES;
      h_next.chunk = 3'(rel);
      h_next.lap   = tkt[LAP_W-1:IDX_W];
      h_next.state = ST_POSTED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_r       <= '0;
        h_r.chunk <= 3'd0;
        h_r.lap   <= 2'b11;
        h_r.state <= ST_FREE;
      end else if (hit) begin
        d_r <= d_next;
        h_r <= h_next;
      end else if (retire && (tail_idx == SLOT)) begin
        h_r.state <= ST_DONE;
      end
    end

    assign hdrs[g]      = h_r;
    assign slot_desc[g] = d_r;
  end

  assign tail_desc = slot_desc[tail_idx];
  assign tail_hdr  = hdrs[tail_idx];

endmodule

// File: rtl/dq_poll.sv
module dq_poll
  import dq_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int LAP_W = IDX_W + 2
) (
  input  slot_hdr_t        hdrs [DEPTH],
  input  logic [63:0]      poll_ticket,
  input  logic [CNT_W-1:0] poll_count,
  output logic             poll_busy
);

  logic [LAP_W-1:0] t_lo;
  logic [IDX_W-1:0] slot;

  always_comb begin
    poll_busy = 1'b0;
    t_lo      = '0;
    slot      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (CNT_W'(k) < poll_count) begin
        t_lo = poll_ticket[LAP_W-1:0] + LAP_W'(k);
        slot = t_lo[IDX_W-1:0];
        if (!slot_settled(hdrs[slot], t_lo[LAP_W-1:IDX_W])) poll_busy = 1'b1;
      end
    end
  end

endmodule

// File: rtl/desc_ring_queue.sv
module desc_ring_queue
  import dq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int CHUNK_SHIFT = 8,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int CNT_W      = IDX_W + 1,
  localparam int LAP_W      = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      cfg_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_offset,
  input  logic [31:0]      req_len,
  input  logic [63:0]      req_dst,
  output logic             enq_done,
  output logic             enq_err,
  output logic [63:0]      enq_ticket,
  output logic [IDX_W-1:0] enq_slot,
  output logic [CNT_W-1:0] enq_count,
  output logic             cons_valid,
  output logic [63:0]      cons_src,
  output logic [31:0]      cons_len,
  output logic [63:0]      cons_dst,
  output logic [2:0]       cons_chunk,
  input  logic             cons_retire,
  input  logic [63:0]      poll_ticket,
  input  logic [CNT_W-1:0] poll_count,
  output logic             poll_busy
);

  // named internal events, observed by the bound checker
  logic             accept_w;
  logic             reject_w;
  logic             retire_w;
  logic [CNT_W-1:0] needed_w;
  logic [CNT_W-1:0] occ_w;
  logic [63:0]      submit_cnt_w;
  logic [63:0]      comp_cnt_w;
  logic [63:0]      src0_w;
  slot_hdr_t        hdr_w [DEPTH];
  desc_t            tail_desc_w;
  slot_hdr_t        tail_hdr_w;

  assign src0_w     = add64_split(cfg_base, req_offset);
  assign cons_valid = (tail_hdr_w.state == ST_POSTED);
  assign retire_w   = cons_retire && cons_valid;
  assign cons_src   = tail_desc_w.src;
  assign cons_len   = tail_desc_w.len;
  assign cons_dst   = tail_desc_w.dst;
  assign cons_chunk = tail_hdr_w.chunk;

  dq_alloc #(.DEPTH(DEPTH), .CHUNK_SHIFT(CHUNK_SHIFT)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_len   (req_len),
    .retire    (retire_w),
    .req_ready (req_ready),
    .accept    (accept_w),
    .reject    (reject_w),
    .needed    (needed_w),
    .occ       (occ_w),
    .submit_cnt(submit_cnt_w),
    .comp_cnt  (comp_cnt_w)
  );

  dq_slot_store #(.DEPTH(DEPTH), .CHUNK_SHIFT(CHUNK_SHIFT)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept_w),
    .needed   (needed_w),
    .head     (submit_cnt_w[LAP_W-1:0]),
    .src0     (src0_w),
    .req_len  (req_len),
    .req_dst  (req_dst),
    .retire   (retire_w),
    .tail_idx (comp_cnt_w[IDX_W-1:0]),
    .hdrs     (hdr_w),
    .tail_desc(tail_desc_w),
    .tail_hdr (tail_hdr_w)
  );

  dq_poll #(.DEPTH(DEPTH)) u_poll (
    .hdrs       (hdr_w),
    .poll_ticket(poll_ticket),
    .poll_count (poll_count),
    .poll_busy  (poll_busy)
  );

  // enqueue result, registered one cycle after the handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enq_done   <= 1'b0;
      enq_err    <= 1'b0;
      enq_ticket <= '0;
      enq_slot   <= '0;
      enq_count  <= '0;
    end else begin
      enq_done <= accept_w;
      enq_err  <= reject_w;
      if (accept_w) begin
        enq_ticket <= submit_cnt_w;
        enq_slot   <= submit_cnt_w[IDX_W-1:0];
        enq_count  <= needed_w;
      end
    end
  end

endmodule

// File: rtl/dq_checker.sv
module dq_checker #(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      req_len,
  input logic             req_ready,
  input logic             accept,
  input logic             reject,
  input logic             retire,
  input logic [CNT_W-1:0] needed,
  input logic [CNT_W-1:0] occ,
  input logic [63:0]      submit_cnt,
  input logic [63:0]      comp_cnt,
  input logic             cons_valid,
  input logic             enq_done,
  input logic             enq_err
);

  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH) && req_len != 32'd0 && needed != '0) |-> !req_ready);

  assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  assert_reject_no_alloc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (submit_cnt == $past(submit_cnt)));

  assert_accept_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (needed != '0 && needed <= CNT_W'(DEPTH)));

  assert_submit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (submit_cnt == $past(submit_cnt) + 64'($past(needed))));

  assert_comp_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (comp_cnt == $past(comp_cnt) + 64'd1));

  assert_offer_matches_occ_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cons_valid == (occ != '0));

  assert_result_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(enq_done && enq_err));

endmodule

bind desc_ring_queue dq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_len   (req_len),
  .req_ready (req_ready),
  .accept    (accept_w),
  .reject    (reject_w),
  .retire    (retire_w),
  .needed    (needed_w),
  .occ       (occ_w),
  .submit_cnt(submit_cnt_w),
  .comp_cnt  (comp_cnt_w),
  .cons_valid(cons_valid),
  .enq_done  (enq_done),
  .enq_err   (enq_err)
);

// File: tb/sim_desc_ring_queue.sv
`timescale 1ns/1ps
module sim_desc_ring_queue;

  localparam int DEPTH = 8;
  localparam int SHIFT = 8;
  localparam longint unsigned CHUNK = 64'd1 << SHIFT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cfg_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_offset = '0;
  logic [31:0] req_len = '0;
  logic [63:0] req_dst = '0;
  logic        enq_done, enq_err;
  logic [63:0] enq_ticket;
  logic [2:0]  enq_slot;
  logic [3:0]  enq_count;
  logic        cons_valid;
  logic [63:0] cons_src, cons_dst;
  logic [31:0] cons_len;
  logic [2:0]  cons_chunk;
  logic        cons_retire = 1'b0;
  logic [63:0] poll_ticket = '0;
  logic [3:0]  poll_count = '0;
  logic        poll_busy;

  desc_ring_queue #(.DEPTH(DEPTH), .CHUNK_SHIFT(SHIFT)) u0 (.*);

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench model
  longint unsigned m_submit = 0;
  longint unsigned m_comp   = 0;
  longint unsigned m_src [4096];
  longint unsigned m_dst [4096];
  int unsigned     m_len [4096];
  int unsigned     m_chk [4096];
  longint unsigned last_ticket = 0;
  int unsigned     last_count = 0;

  task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned f_chunks(input int unsigned len);
    return (longint'(len) + CHUNK - 1) / CHUNK;
  endfunction

  function automatic longint unsigned f_src(input longint unsigned base, input int unsigned off, input int unsigned k);
    return base + longint'(off) + longint'(k) * CHUNK;
  endfunction

  task automatic do_req(input int unsigned off, input int unsigned len, input longint unsigned dst);
    longint unsigned need;
    bit bad, fits;
    need = f_chunks(len);
    bad  = (len == 0) || (need > DEPTH);
    fits = !bad && (need <= DEPTH - (m_submit - m_comp));
    @(negedge clk);
    req_valid = 1'b1; req_offset = off; req_len = len; req_dst = dst;
    #1;
    chk(req_ready == (bad || fits), "R6 ready", req_ready, bad || fits);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      chk(enq_err === 1'b1 && enq_done === 1'b0, (len == 0) ? "R4 zero" : "R5 oversize", {enq_err, enq_done}, 2'b10);
    end else if (fits) begin
      chk(enq_done === 1'b1, "R2 done", enq_done, 1);
      chk(enq_ticket == m_submit, "R2 ticket", enq_ticket, m_submit);
      chk(enq_slot == 3'(m_submit % DEPTH) && enq_count == 4'(need), "R2 slot/count",
          {enq_slot, enq_count}, {3'(m_submit % DEPTH), 4'(need)});
      for (int k = 0; k < int'(need); k++) begin
        int unsigned ix;
        ix = int'((m_submit + k) % 4096);
        m_src[ix] = f_src(cfg_base, off, k);
        m_dst[ix] = dst + longint'(k) * CHUNK;
        m_len[ix] = (k == int'(need) - 1) ? len - k * int'(CHUNK) : int'(CHUNK);
        m_chk[ix] = k % 8;
      end
      last_ticket = m_submit;
      last_count  = int'(need);
      m_submit += need;
    end else begin
      chk(enq_done === 1'b0 && enq_err === 1'b0, "R6 blocked", {enq_done, enq_err}, 0);
    end
  endtask

  task automatic do_retire();
    bit exp_v;
    int unsigned ix;
    @(negedge clk);
    exp_v = (m_submit != m_comp);
    ix = int'(m_comp % 4096);
    chk(cons_valid == exp_v, "R7 valid", cons_valid, exp_v);
    if (exp_v) begin
      chk(cons_src == m_src[ix], "R3 src", cons_src, m_src[ix]);
      chk(cons_dst == m_dst[ix] && cons_len == m_len[ix], "R3 dst/len", cons_len, m_len[ix]);
      chk(cons_chunk == 3'(m_chk[ix]), "R10 chunk", cons_chunk, m_chk[ix]);
    end
    cons_retire = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cons_retire = 1'b0;
    if (exp_v) m_comp++;
    #1;
    chk(cons_valid == (m_submit != m_comp), "R7 after retire", cons_valid, m_submit != m_comp);
  endtask

  task automatic do_poll(input longint unsigned t, input int unsigned n);
    bit exp_b;
    @(negedge clk);
    poll_ticket = t; poll_count = 4'(n);
    #1;
    exp_b = 1'b0;
    for (int k = 0; k < int'(n); k++) if (t + k >= m_comp) exp_b = 1'b1;
    chk(poll_busy == exp_b, "R9 poll", poll_busy, exp_b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint unsigned t0;
    cfg_base = 64'h0000_0001_FFFF_FF00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    req_len = 32'd16;
    poll_ticket = 0; poll_count = 4'd1;
    #1;
    // R1 reset state
    chk(cons_valid == 1'b0 && enq_done == 1'b0 && enq_err == 1'b0, "R1 idle", {cons_valid, enq_done, enq_err}, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(poll_busy == 1'b1, "R1 poll busy", poll_busy, 1);
    poll_count = 4'd0; #1;
    chk(poll_busy == 1'b0, "R1 poll empty", poll_busy, 0);

    // R3 carry across the 32-bit halves
    do_req(32'h200, 256, 64'h10_0000);
    chk(m_src[0] == 64'h0000_0002_0000_0100, "R3 carry model", m_src[0], 64'h0000_0002_0000_0100);
    do_poll(0, 1);
    do_retire();
    do_poll(0, 1);
    // multi-chunk with remainder
    do_req(32'h40, 700, 64'h20_0000);
    t0 = last_ticket;
    do_poll(t0, 3);
    do_retire(); do_retire();
    do_poll(t0, 3);
    do_retire();
    do_poll(t0, 3);
    // R4 / R5 rejections, ticket not consumed
    do_req(32'h0, 0, 64'h0);
    do_req(32'h0, 2049, 64'h0);
    do_req(32'h0, 2048, 64'h30_0000);
    chk(last_ticket == 64'd4, "R4 ticket kept", last_ticket, 4);
    // R6 full ring
    do_req(32'h0, 1, 64'h0);
    do_retire();
    do_req(32'h0, 1, 64'h0);
    // R7 retire with nothing offered
    while (m_comp != m_submit) do_retire();
    do_retire();
    do_poll(t0, 3);

    // random mix, many laps
    cfg_base = {$urandom(32'd7), 32'hFFFF_F000};
    for (int i = 0; i < 1500; i++) begin
      int unsigned c;
      c = $urandom_range(0, 9);
      if (c < 5) begin
        int unsigned len;
        len = (c == 0) ? $urandom_range(0, 2300) : $urandom_range(1, 600);
        if ($urandom_range(0, 30) == 0) len = 0;
        do_req($urandom, len, {$urandom, $urandom});
      end else if (c < 8) begin
        do_retire();
      end else begin
        do_poll(last_ticket, last_count);
      end
      if (i == 750) cfg_base = {$urandom, $urandom};
    end
    chk(m_submit > 64'd3 * DEPTH, "R8 laps", m_submit, 3 * DEPTH);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule